// File: doc/BRIEF.md
# Normalizing Barrel Shifter Unit

This unit is the shift stage of a 16-bit fixed-point datapath. Each accepted operation places the 16-bit operand into a 32-bit field, either in the upper half or in the lower half, so that multiword values can be assembled. It then shifts the field logically or arithmetically by a signed amount. The same shifter also measures how many redundant sign bits a word carries, normalizes a word by that count, and scales words up or down by a shared block exponent. Block floating-point code uses these together: it scans a block of samples, keeps the smallest exponent it has seen, and scales the whole block by that one value.

Every operation is issued with a one-cycle strobe. Its result, exponent and updated block exponent are registered, so the next unit can use them on the following cycle. When no operation is issued, the outputs and the block exponent keep their values.

Top module: `nbs_unit`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0, `out_result` is 0, `out_exp` is 0 and `blk_exp` is 15.
- R2: An operation issued with `in_valid` high produces `out_valid` high on the next rising edge, with its results on `out_result` and `out_exp`. When `in_valid` is low, `out_valid` goes low and `out_result`, `out_exp` and `blk_exp` hold their values whatever the other inputs do.
- R3: Opcode 0 performs a logical shift. With `in_hi`=1 the field is {data, 16'h0000}; with `in_hi`=0 it is {16'h0000, data}. `in_amt` is a two's-complement count: a positive count shifts left, a negative count shifts right, and zeros fill the vacated bits. A count of magnitude 32 or more, including -128, gives 0. `out_exp` is 0.
- R4: Opcode 1 performs an arithmetic shift. With `in_hi`=0 the field is the sign-extended data; with `in_hi`=1 it is {data, 16'h0000}. A right shift fills with bit 31 of the field and a left shift fills with zeros. A right shift of 32 or more gives 32 copies of the sign bit. `out_exp` is 0.
- R5: Opcode 2 derives the exponent. `out_exp` becomes the number of bits below bit 15 that match bit 15 before the first bit that differs, which lies in the range 0 to 14. Data 16'h0000 and 16'hFFFF give 15. `out_result` is 0.
- R6: Opcode 3 normalizes. `out_result` is {data, 16'h0000} shifted left by the derived exponent, and `out_exp` is that exponent. For data other than 16'h0000 and 16'hFFFF, bits 31 and 30 of the result differ.
- R7: Opcode 4 derives the exponent as in R5, drives it on `out_exp` with `out_result` = 0, and loads `blk_exp` with the smaller of `blk_exp` and that exponent. No other opcode lowers `blk_exp`.
- R8: Opcode 5 sets `blk_exp` to 15, drives `out_exp` = 15 and gives `out_result` = 0.
- R9: Opcode 6 denormalizes. `out_result` is {data, 16'h0000} shifted right arithmetically by `blk_exp`, and `out_exp` is `blk_exp`.
- R10: Opcode 7 scales by the block exponent. `out_result` is {data, 16'h0000} shifted left by `blk_exp`, and `out_exp` is `blk_exp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe for one operation |
| in_op | input | 3 | Opcode, 0 to 7 |
| in_hi | input | 1 | Placement of the operand: 1 for the upper half of the field, 0 for the lower half |
| in_data | input | 16 | Operand word |
| in_amt | input | 8 | Signed shift count for opcodes 0 and 1 |
| out_valid | output | 1 | Result strobe, one cycle after the issue strobe |
| out_result | output | 32 | Shifted field |
| out_exp | output | 8 | Derived or applied exponent |
| blk_exp | output | 8 | Shared block exponent |

## Verification
All three outputs of an operation, and the block-exponent update it causes, are due at the first rising edge after the cycle in which the operation is presented with `in_valid` high. The bench drives each operation on a falling edge, lowers `in_valid` on the next falling edge and samples there, half a period after the edge that registered the result. Hold and ignore behaviour is checked the same way, across several idle cycles whose inputs carry block-changing opcodes. Table order matters for the block-exponent vectors, because each one depends on the state the earlier rows left behind.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [2:0] {
    OP_LSH     = 3'd0,
    OP_ASH     = 3'd1,
    OP_EXP     = 3'd2,
    OP_NORM    = 3'd3,
    OP_EXPBLK  = 3'd4,
    OP_BLKCLR  = 3'd5,
    OP_DENORM  = 3'd6,
    OP_NORMBLK = 3'd7
  } nbs_op_e;
endpackage

// File: rtl/nbs_expdet.sv
// Counts the bits below the sign bit that equal it, stopping at the first mismatch.
module nbs_expdet #(
  parameter int DW = 16,
  parameter int EW = 8
) (
  input  logic [DW-1:0] d,
  output logic [EW-1:0] cnt
);
  int   acc;
  logic run;

  always_comb begin
    acc = 0;
    run = 1'b1;
    for (int i = DW - 2; i >= 0; i--) begin
      if (run && (d[i] == d[DW-1])) begin
        acc = acc + 1;
      end else begin
        run = 1'b0;
      end
    end
    cnt = EW'(acc);
  end
endmodule

// File: rtl/nbs_barrel.sv
// Logarithmic shifter. Right shifts fill with fill_bit. Left shifts are done by
// reversing the bits, shifting right with zero fill, and reversing back.
module nbs_barrel #(
  parameter int W  = 32,
  parameter int SW = 6
) (
  input  logic [W-1:0]  din,
  input  logic          left,
  input  logic          fill_bit,
  input  logic [SW-1:0] sh,
  output logic [W-1:0]  dout
);
  logic [W-1:0] din_rev;
  logic [W-1:0] fin_rev;
  logic         fb;
  logic [W-1:0] stg [SW+1];

  always_comb begin
    for (int i = 0; i < W; i++) din_rev[i] = din[W-1-i];
  end

  assign fb     = left ? 1'b0 : fill_bit;
  assign stg[0] = left ? din_rev : din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    if (STEP >= W) begin : g_all
      assign stg[k+1] = sh[k] ? {W{fb}} : stg[k];
    end else begin : g_part
      assign stg[k+1] = sh[k] ? {{STEP{fb}}, stg[k][W-1:STEP]} : stg[k];
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) fin_rev[i] = stg[SW][W-1-i];
  end

  assign dout = left ? fin_rev : stg[SW];
endmodule

// File: rtl/nbs_blkexp.sv
// Shared block exponent: clears to the maximum count and keeps the minimum seen.
module nbs_blkexp #(
  parameter int EW     = 8,
  parameter int MAXEXP = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [EW-1:0] new_exp,
  output logic [EW-1:0] q
);
  logic [EW-1:0] q_n;
  logic          en;

  assign en = clr | upd;

  always_comb begin
    q_n = q;
    if (clr) begin
      q_n = EW'(MAXEXP);
    end else if (upd && (new_exp < q)) begin
      q_n = new_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= EW'(MAXEXP);
    end else if (en) begin
      q <= q_n;
    end
  end
endmodule

// File: rtl/nbs_unit.sv
module nbs_unit #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int EW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       in_op,
  input  logic             in_hi,
  input  logic [DW-1:0]    in_data,
  input  logic [AW-1:0]    in_amt,
  output logic             out_valid,
  output logic [2*DW-1:0]  out_result,
  output logic [EW-1:0]    out_exp,
  output logic [EW-1:0]    blk_exp
);
  import nbs_pkg::*;

  localparam int RW     = 2 * DW;
  localparam int SW     = $clog2(RW) + 1;
  localparam int MAXEXP = DW - 1;

  nbs_op_e        op;
  logic           amt_neg;
  logic [AW-1:0]  amt_mag;
  logic [SW-1:0]  amt_sat;
  logic [EW-1:0]  exp_d;
  logic [RW-1:0]  f_hi, f_lo_log, f_lo_ari;
  logic [RW-1:0]  bs_in, bs_out;
  logic           bs_left, bs_fill;
  logic [SW-1:0]  bs_sh;
  logic [RW-1:0]  res_c, res_n;
  logic [EW-1:0]  exp_c, exp_n;
  logic           use_bs;
  logic           blk_clr, blk_upd;

  assign op = nbs_op_e'(in_op);

  // Signed count to saturated magnitude
  assign amt_neg = in_amt[AW-1];
  assign amt_mag = amt_neg ? (~in_amt + 1'b1) : in_amt;
  assign amt_sat = (32'(amt_mag) >= RW) ? SW'(RW) : SW'(amt_mag);

  // Operand placement
  assign f_hi     = {in_data, {DW{1'b0}}};
  assign f_lo_log = {{DW{1'b0}}, in_data};
  assign f_lo_ari = {{DW{in_data[DW-1]}}, in_data};

  nbs_expdet #(.DW(DW), .EW(EW)) u_expdet (
    .d   (in_data),
    .cnt (exp_d)
  );

  always_comb begin
    bs_in   = f_hi;
    bs_left = 1'b1;
    bs_fill = 1'b0;
    bs_sh   = '0;
    use_bs  = 1'b0;
    exp_c   = '0;
    unique case (op)
      OP_LSH: begin
        bs_in   = in_hi ? f_hi : f_lo_log;
        bs_left = ~amt_neg;
        bs_sh   = amt_sat;
        use_bs  = 1'b1;
      end
      OP_ASH: begin
        bs_in   = in_hi ? f_hi : f_lo_ari;
        bs_left = ~amt_neg;
        bs_fill = in_hi ? in_data[DW-1] : f_lo_ari[RW-1];
        bs_sh   = amt_sat;
        use_bs  = 1'b1;
      end
      OP_EXP, OP_EXPBLK: begin
        exp_c = exp_d;
      end
      OP_NORM: begin
        bs_sh  = SW'(exp_d);
        use_bs = 1'b1;
        exp_c  = exp_d;
      end
      OP_BLKCLR: begin
        exp_c = EW'(MAXEXP);
      end
      OP_DENORM: begin
        bs_left = 1'b0;
        bs_fill = in_data[DW-1];
        bs_sh   = SW'(blk_exp);
        use_bs  = 1'b1;
        exp_c   = blk_exp;
      end
      OP_NORMBLK: begin
        bs_sh  = SW'(blk_exp);
        use_bs = 1'b1;
        exp_c  = blk_exp;
      end
      default: ;
    endcase
  end

  nbs_barrel #(.W(RW), .SW(SW)) u_barrel (
    .din      (bs_in),
    .left     (bs_left),
    .fill_bit (bs_fill),
    .sh       (bs_sh),
    .dout     (bs_out)
  );

  assign res_c   = use_bs ? bs_out : '0;
  assign blk_clr = in_valid && (op == OP_BLKCLR);
  assign blk_upd = in_valid && (op == OP_EXPBLK);

  nbs_blkexp #(.EW(EW), .MAXEXP(MAXEXP)) u_blkexp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (blk_clr),
    .upd     (blk_upd),
    .new_exp (exp_d),
    .q       (blk_exp)
  );

  // Output next state
  assign res_n = in_valid ? res_c : out_result;
  assign exp_n = in_valid ? exp_c : out_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_exp    <= '0;
    end else begin
      out_valid  <= in_valid;
      out_result <= res_n;
      out_exp    <= exp_n;
    end
  end
endmodule

// File: rtl/nbs_unit_chk.sv
module nbs_unit_chk #(
  parameter int DW = 16,
  parameter int EW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [2:0]      in_op,
  input logic [DW-1:0]   in_data,
  input logic            out_valid,
  input logic [2*DW-1:0] out_result,
  input logic [EW-1:0]   out_exp,
  input logic [EW-1:0]   blk_exp
);
  localparam int RW = 2 * DW;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_exp) && $stable(blk_exp))); // R2
  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_exp <= EW'(DW - 1)); // R5
  AST_NORM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd3 && in_data != '0 && in_data != '1)
      |=> (out_result[RW-1] != out_result[RW-2])); // R6
  AST_BLK_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd4) |=> (blk_exp <= $past(blk_exp) && blk_exp <= out_exp)); // R7
  AST_BLK_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_op == 3'd5) |=> (blk_exp <= $past(blk_exp))); // R7
  AST_BLK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd5) |=> (blk_exp == EW'(DW - 1) && out_result == '0)); // R8
endmodule

bind nbs_unit nbs_unit_chk #(.DW(DW), .EW(EW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_exp    (out_exp),
  .blk_exp    (blk_exp)
);

// File: tb/nbs_unit_bench.sv
module nbs_unit_bench;
  localparam int NV = 20;
  // {op[3], hi[1], data[16], amt[8], result[32], exp[8], blk[8]}
  localparam logic [75:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'h00F0, 8'h04, 32'h00000F00, 8'd0,  8'd15}, // R3 lo left
    {3'd0, 1'b0, 16'h00F0, 8'hFC, 32'h0000000F, 8'd0,  8'd15}, // R3 lo right
    {3'd0, 1'b1, 16'h8001, 8'hFF, 32'h40008000, 8'd0,  8'd15}, // R3 hi right
    {3'd0, 1'b1, 16'h1234, 8'h28, 32'h00000000, 8'd0,  8'd15}, // R3 over range
    {3'd1, 1'b0, 16'h8000, 8'hFC, 32'hFFFFF800, 8'd0,  8'd15}, // R4 sign fill
    {3'd1, 1'b1, 16'h8000, 8'h9C, 32'hFFFFFFFF, 8'd0,  8'd15}, // R4 far right
    {3'd1, 1'b0, 16'hFFFF, 8'h03, 32'hFFFFFFF8, 8'd0,  8'd15}, // R4 left zero fill
    {3'd2, 1'b0, 16'h0001, 8'h00, 32'h00000000, 8'd14, 8'd15}, // R5
    {3'd2, 1'b0, 16'hC000, 8'h00, 32'h00000000, 8'd1,  8'd15}, // R5
    {3'd2, 1'b0, 16'h0000, 8'h00, 32'h00000000, 8'd15, 8'd15}, // R5 zero
    {3'd2, 1'b0, 16'hFFFF, 8'h00, 32'h00000000, 8'd15, 8'd15}, // R5 all ones
    {3'd3, 1'b0, 16'h0300, 8'h00, 32'h60000000, 8'd5,  8'd15}, // R6
    {3'd3, 1'b0, 16'hFE00, 8'h00, 32'h80000000, 8'd6,  8'd15}, // R6
    {3'd4, 1'b0, 16'h0100, 8'h00, 32'h00000000, 8'd6,  8'd6 }, // R7
    {3'd4, 1'b0, 16'h1000, 8'h00, 32'h00000000, 8'd2,  8'd2 }, // R7
    {3'd4, 1'b0, 16'h0008, 8'h00, 32'h00000000, 8'd11, 8'd2 }, // R7 larger kept out
    {3'd7, 1'b0, 16'h0100, 8'h00, 32'h04000000, 8'd2,  8'd2 }, // R10
    {3'd6, 1'b0, 16'h8000, 8'h00, 32'hE0000000, 8'd2,  8'd2 }, // R9
    {3'd5, 1'b0, 16'h1234, 8'h00, 32'h00000000, 8'd15, 8'd15}, // R8
    {3'd6, 1'b0, 16'h4000, 8'h00, 32'h00008000, 8'd15, 8'd15}  // R9 after clear
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_op;
  logic        in_hi;
  logic [15:0] in_data;
  logic [7:0]  in_amt;
  logic        out_valid;
  logic [31:0] out_result;
  logic [7:0]  out_exp;
  logic [7:0]  blk_exp;

  int n_chk;
  int n_fail;
  bit done;

  nbs_unit u_nbs_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_hi      (in_hi),
    .in_data    (in_data),
    .in_amt     (in_amt),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_exp    (out_exp),
    .blk_exp    (blk_exp)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Present one operation for one cycle; return at the sampling point.
  task automatic issue(input logic [2:0] op, input logic hi, input logic [15:0] d,
                       input logic [7:0] amt);
    @(negedge clk);
    in_op = op; in_hi = hi; in_data = d; in_amt = amt; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] held_res;
    logic [7:0]  held_exp;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_op = 3'd0; in_hi = 1'b0;
    in_data = 16'h0; in_amt = 8'h0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 valid in reset", 32'(out_valid), 32'd0);
    chk("R1 result in reset", out_result, 32'h0);
    chk("R1 exp in reset", 32'(out_exp), 32'd0);
    chk("R1 blk in reset", 32'(blk_exp), 32'd15);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 blk after reset", 32'(blk_exp), 32'd15);
    chk("R1 valid after reset", 32'(out_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][75:73], VEC[i][72], VEC[i][71:56], VEC[i][55:48]);
      chk($sformatf("R2 valid vec %0d", i), 32'(out_valid), 32'd1);
      chk($sformatf("result vec %0d op %0d", i, VEC[i][75:73]), out_result, VEC[i][47:16]);
      chk($sformatf("exp vec %0d op %0d", i, VEC[i][75:73]), 32'(out_exp), 32'(VEC[i][15:8]));
      chk($sformatf("R7 blk vec %0d", i), 32'(blk_exp), 32'(VEC[i][7:0]));
    end

    // R2 / R7: idle cycles with block-changing opcodes on the inputs are ignored
    held_res = out_result;
    held_exp = out_exp;
    in_op = 3'd4; in_data = 16'h0001;
    @(negedge clk);
    in_op = 3'd5;
    @(negedge clk);
    in_op = 3'd0; in_data = 16'hFFFF; in_amt = 8'h01;
    @(negedge clk);
    chk("R2 idle valid low", 32'(out_valid), 32'd0);
    chk("R2 idle result held", out_result, held_res);
    chk("R2 idle exp held", 32'(out_exp), 32'(held_exp));
    chk("R7 idle blk held", 32'(blk_exp), 32'd15);

    // R3: count of -128 clears the field
    issue(3'd0, 1'b1, 16'hFFFF, 8'h80);
    chk("R3 count -128", out_result, 32'h0);
    // R4: zero count passes sign-extended lower placement
    issue(3'd1, 1'b0, 16'h8421, 8'h00);
    chk("R4 zero count", out_result, 32'hFFFF8421);
    // R4: exact 32 right on a positive value
    issue(3'd1, 1'b1, 16'h7FFF, 8'hE0);
    chk("R4 right 32 positive", out_result, 32'h0);
    // R3: left 31 keeps one bit
    issue(3'd0, 1'b0, 16'h0001, 8'h1F);
    chk("R3 left 31", out_result, 32'h80000000);
    // R6: zero normalizes to zero with the maximum count
    issue(3'd3, 1'b0, 16'h0000, 8'h00);
    chk("R6 zero result", out_result, 32'h0);
    chk("R6 zero exp", 32'(out_exp), 32'd15);
    // R7 then R10 with exponent 0
    issue(3'd4, 1'b0, 16'h4000, 8'h00);
    chk("R7 exponent 0", 32'(blk_exp), 32'd0);
    issue(3'd7, 1'b0, 16'h4000, 8'h00);
    chk("R10 block 0", out_result, 32'h40000000);
    // R9: denormalize by 0 keeps the field
    issue(3'd6, 1'b0, 16'hC001, 8'h00);
    chk("R9 block 0", out_result, 32'hC0010000);

    // R1: reset mid-run restores the block exponent
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset blk", 32'(blk_exp), 32'd15);
    chk("R1 mid reset result", out_result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    finish_run();
  end
endmodule